// File: doc/BRIEF.md
# Serial Test-Packet DUT Sequencer

This block listens to a slow serial line, one bit per period of a recovered bit clock, and hunts for a fixed start pattern. Once the pattern is found it collects the data word that follows. It then uses each data bit as stimulus for an external positive-edge D flip-flop under test: it drives the flip-flop's data pin, gives it a single clock pulse, and reads back the flip-flop's output.

When every bit has been exercised, the block sends a reply frame on a serial output. The reply is the same start pattern followed by the captured responses. It then returns to the hunt, so further packets can be handled without a reset.

A clock-qualification input gates all activity. While the recovered clock is not yet trusted, for example during the training sequence that precedes test data, the line is ignored. If qualification drops mid-packet, the sequence is abandoned and the reply line falls idle.

Top module: `sdt_sequencer`

## Requirements
- R1: While reset is asserted and after its release, `ser_out`, `dut_clk` and `dut_d` are 0 until a packet is processed.
- R2: A packet begins with the start pattern 1,0,1,0 (first received bit first). Detection uses a sliding window. It matches at the earliest bit where the last four qualified bits form the pattern, so stray leading bits or a broken partial pattern before it do not prevent the match.
- R3: The four bits that immediately follow the pattern are the data word, received most significant bit first.
- R4: Stimulus starts the cycle after the last data bit is sampled. For each data bit, highest first, the block spends three cycles: setup (`dut_d` = bit, `dut_clk` = 0), pulse (`dut_d` = bit, `dut_clk` = 1), and sample (`dut_clk` = 0).
- R5: The response to each bit is the value of `dut_q` at the end of that bit's sample cycle.
- R6: On the cycle after the last sample cycle, `ser_out` sends eight bits, one per cycle: 1,0,1,0 followed by the four responses, highest bit first.
- R7: After the reply, `ser_out` returns to 0 and the block hunts again. Line activity during data stimulus and reply is ignored, and a following packet is handled normally.
- R8: While `clk_ok` is 0, line bits are not examined and no partial pattern is kept. Dropping `clk_ok` at any point aborts the packet: from the next cycle `ser_out` and `dut_clk` are 0, and no stimulus resumes when `clk_ok` returns.
- R9: `dut_clk` is high for exactly one cycle per data bit, and `dut_d` does not change across the pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Recovered bit clock, one line bit per rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| clk_ok | input | 1 | High when the recovered clock is qualified |
| ser_in | input | 1 | Incoming serial test line |
| dut_q | input | 1 | Output of the flip-flop under test |
| dut_d | output | 1 | Data pin stimulus to the flip-flop under test |
| dut_clk | output | 1 | Clock pulse to the flip-flop under test |
| ser_out | output | 1 | Serial reply line, idle low |

## Verification
The bench builds the block with its default configuration: a four-bit pattern of 1010 and a four-bit data word. This keeps the packet space small enough to sweep every data value. Each value is run against a modelled flip-flop in both true and inverted output polarity, so the reply can only match if it really comes from `dut_q`. The short pattern also makes the overlap cases (repeated 10 pairs, stray leading ones, a broken 1011 prefix) and the abort points in hunt, data, stimulus and reply reachable with hand-built bit strings.

// File: rtl/sdt_pkg.sv
package sdt_pkg;

    typedef enum logic [1:0] {
        ST_HUNT  = 2'd0,
        ST_DATA  = 2'd1,
        ST_TEST  = 2'd2,
        ST_REPLY = 2'd3
    } seq_state_e;

    typedef enum logic [1:0] {
        PH_SETUP  = 2'd0,
        PH_PULSE  = 2'd1,
        PH_SAMPLE = 2'd2
    } stim_phase_e;

endpackage

// File: rtl/sdt_pre_detect.sv
// Sliding-window start-pattern matcher. The window keeps shifting on a miss,
// so overlapping candidates are never lost. It clears itself on a hit or
// whenever it is disabled.
module sdt_pre_detect #(
    parameter int              PRE_LEN = 4,
    parameter logic [PRE_LEN-1:0] PRE_PAT = 4'b1010
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    input  logic bit_in,
    output logic hit
);
    localparam int FILL_W = (PRE_LEN > 2) ? $clog2(PRE_LEN) : 1;

    typedef struct packed {
        logic [PRE_LEN-1:0] win;
        logic [FILL_W-1:0]  fill;
    } det_t;

    det_t r, n;
    logic [PRE_LEN-1:0] shifted;

    always_comb begin
        n       = r;
        shifted = {r.win[PRE_LEN-2:0], bit_in};
        hit     = en && (r.fill == FILL_W'(PRE_LEN-1)) && (shifted == PRE_PAT);
        if (!en || hit) begin
            n.fill = '0;
            n.win  = '0;
        end else begin
            n.win = shifted;
            if (r.fill != FILL_W'(PRE_LEN-1)) begin
                n.fill = r.fill + FILL_W'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r <= '0;
        end else begin
            r <= n;
        end
    end

endmodule

// File: rtl/sdt_stim_drv.sv
// Decodes the stimulus pins from the registered sequencing state.
module sdt_stim_drv
    import sdt_pkg::*;
#(
    parameter int DATA_BITS = 4,
    parameter int CNT_W     = 3
) (
    input  logic                 active,
    input  stim_phase_e          phase,
    input  logic [DATA_BITS-1:0] data,
    input  logic [CNT_W-1:0]     idx,
    output logic                 d_out,
    output logic                 clk_out
);
    logic [CNT_W-1:0] sel;

    always_comb begin
        sel     = CNT_W'(DATA_BITS-1) - idx;
        d_out   = active & data[sel];
        clk_out = active && (phase == PH_PULSE);
    end

endmodule

// File: rtl/sdt_reply_ser.sv
// Selects the current reply bit: start pattern, then responses, MSB first.
module sdt_reply_ser #(
    parameter int                 PRE_LEN   = 4,
    parameter logic [PRE_LEN-1:0] PRE_PAT   = 4'b1010,
    parameter int                 DATA_BITS = 4,
    parameter int                 CNT_W     = 3
) (
    input  logic                 active,
    input  logic [CNT_W-1:0]     idx,
    input  logic [DATA_BITS-1:0] resp,
    output logic                 bit_out
);
    localparam int FRAME = PRE_LEN + DATA_BITS;

    logic [FRAME-1:0] frame;
    logic [CNT_W-1:0] sel;

    always_comb begin
        frame   = {PRE_PAT, resp};
        sel     = CNT_W'(FRAME-1) - idx;
        bit_out = active & frame[sel];
    end

endmodule

// File: rtl/sdt_sequencer.sv
module sdt_sequencer
    import sdt_pkg::*;
#(
    parameter int                 PRE_LEN   = 4,
    parameter logic [PRE_LEN-1:0] PRE_PAT   = 4'b1010,
    parameter int                 DATA_BITS = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clk_ok,
    input  logic ser_in,
    input  logic dut_q,
    output logic dut_d,
    output logic dut_clk,
    output logic ser_out
);
    localparam int FRAME = PRE_LEN + DATA_BITS;
    localparam int CNT_W = $clog2(FRAME);

    typedef struct packed {
        seq_state_e           state;
        stim_phase_e          ph;
        logic [CNT_W-1:0]     cnt;
        logic [DATA_BITS-1:0] data;
        logic [DATA_BITS-1:0] resp;
    } seq_t;

    seq_t r, n;
    logic hit;
    logic det_en;
    logic [CNT_W-1:0] bit_sel;

    assign det_en = clk_ok && (r.state == ST_HUNT);

    sdt_pre_detect #(
        .PRE_LEN (PRE_LEN),
        .PRE_PAT (PRE_PAT)
    ) u_detect (
        .clk    (clk),
        .rst_n  (rst_n),
        .en     (det_en),
        .bit_in (ser_in),
        .hit    (hit)
    );

    always_comb begin
        n       = r;
        bit_sel = CNT_W'(DATA_BITS-1) - r.cnt;
        if (!clk_ok) begin
            n.state = ST_HUNT;
            n.ph    = PH_SETUP;
            n.cnt   = '0;
        end else begin
            case (r.state)
                ST_HUNT: begin
                    if (hit) begin
                        n.state = ST_DATA;
                        n.cnt   = '0;
                    end
                end
                ST_DATA: begin
                    n.data = {r.data[DATA_BITS-2:0], ser_in};
                    if (r.cnt == CNT_W'(DATA_BITS-1)) begin
                        n.state = ST_TEST;
                        n.ph    = PH_SETUP;
                        n.cnt   = '0;
                    end else begin
                        n.cnt = r.cnt + CNT_W'(1);
                    end
                end
                ST_TEST: begin
                    case (r.ph)
                        PH_SETUP: n.ph = PH_PULSE;
                        PH_PULSE: n.ph = PH_SAMPLE;
                        default: begin
                            n.resp[bit_sel] = dut_q;
                            n.ph            = PH_SETUP;
                            if (r.cnt == CNT_W'(DATA_BITS-1)) begin
                                n.state = ST_REPLY;
                                n.cnt   = '0;
                            end else begin
                                n.cnt = r.cnt + CNT_W'(1);
                            end
                        end
                    endcase
                end
                default: begin
                    if (r.cnt == CNT_W'(FRAME-1)) begin
                        n.state = ST_HUNT;
                        n.cnt   = '0;
                    end else begin
                        n.cnt = r.cnt + CNT_W'(1);
                    end
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r <= '0;
        end else begin
            r <= n;
        end
    end

    sdt_stim_drv #(
        .DATA_BITS (DATA_BITS),
        .CNT_W     (CNT_W)
    ) u_stim (
        .active  (r.state == ST_TEST),
        .phase   (r.ph),
        .data    (r.data),
        .idx     (r.cnt),
        .d_out   (dut_d),
        .clk_out (dut_clk)
    );

    sdt_reply_ser #(
        .PRE_LEN   (PRE_LEN),
        .PRE_PAT   (PRE_PAT),
        .DATA_BITS (DATA_BITS),
        .CNT_W     (CNT_W)
    ) u_reply (
        .active  (r.state == ST_REPLY),
        .idx     (r.cnt),
        .resp    (r.resp),
        .bit_out (ser_out)
    );

endmodule

// File: rtl/sdt_sequencer_chk.sv
module sdt_sequencer_chk (
    input logic clk,
    input logic rst_n,
    input logic clk_ok,
    input logic dut_d,
    input logic dut_clk,
    input logic ser_out
);
    // R8: losing clock qualification silences both outputs next cycle
    p_abort_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !clk_ok |=> (!ser_out && !dut_clk));

    // R9: the flip-flop clock pulse is one cycle wide
    p_pulse_width_r9: assert property (@(posedge clk) disable iff (!rst_n)
        dut_clk |=> !dut_clk);

    // R4: data pin already settled when the pulse starts
    p_setup_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(dut_clk) |-> $stable(dut_d));

    // R9: data pin held while the pulse ends
    p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(dut_clk) |-> $stable(dut_d));

    // R6: reply never overlaps stimulus pulses
    p_no_mix_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !(dut_clk && ser_out));

endmodule

bind sdt_sequencer sdt_sequencer_chk u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .clk_ok  (clk_ok),
    .dut_d   (dut_d),
    .dut_clk (dut_clk),
    .ser_out (ser_out)
);

// File: tb/sdt_sequencer_tb.sv
`timescale 1ns/1ps
module sdt_sequencer_tb;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic clk_ok = 1'b0;
    logic ser_in = 1'b0;
    logic dut_q;
    logic dut_d, dut_clk, ser_out;
    logic dut_inv = 1'b0;
    logic q_ff = 1'b0;

    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    // model of the flip-flop under test, optionally inverting
    always_ff @(posedge dut_clk) q_ff <= dut_d ^ dut_inv;
    assign dut_q = q_ff;

    sdt_sequencer u_dut (
        .clk     (clk),
        .rst_n   (rst_n),
        .clk_ok  (clk_ok),
        .ser_in  (ser_in),
        .dut_q   (dut_q),
        .dut_d   (dut_d),
        .dut_clk (dut_clk),
        .ser_out (ser_out)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    task automatic send_seq(input logic [15:0] bits, input int nbits);
        for (int i = nbits - 1; i >= 0; i--) begin
            @(negedge clk);
            ser_in = bits[i];
            @(posedge clk);
        end
    endtask

    // called right after the edge that samples the last data bit
    task automatic expect_packet(input logic [3:0] v, input bit noise);
        logic [7:0] frame;
        logic [3:0] q;
        int tgl = 0;
        q = v ^ {4{dut_inv}};
        frame = {4'b1010, q};
        for (int b = 3; b >= 0; b--) begin
            for (int ph = 0; ph < 3; ph++) begin
                @(negedge clk);
                ser_in = noise ? tgl[0] : 1'b0;
                tgl++;
                if (ph == 1) begin
                    chk(dut_clk == 1'b1, "R9 pulse", int'(dut_clk), 1);
                end else begin
                    chk(dut_clk == 1'b0, "R9 clock low", int'(dut_clk), 0);
                end
                if (ph < 2) begin
                    chk(dut_d == v[b], "R3 R4 stimulus bit", int'(dut_d), int'(v[b]));
                end
            end
        end
        for (int k = 7; k >= 0; k--) begin
            @(negedge clk);
            ser_in = noise ? tgl[0] : 1'b0;
            tgl++;
            chk(ser_out == frame[k], "R5 R6 reply bit", int'(ser_out), int'(frame[k]));
        end
        @(negedge clk);
        ser_in = 1'b0;
        chk(ser_out == 1'b0 && dut_clk == 1'b0, "R7 idle after reply",
            int'({ser_out, dut_clk}), 0);
    endtask

    task automatic quiet(input int cycles, input string req);
        for (int i = 0; i < cycles; i++) begin
            @(negedge clk);
            ser_in = 1'b0;
            chk(dut_clk == 1'b0 && ser_out == 1'b0, req, int'({dut_clk, ser_out}), 0);
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk(ser_out == 1'b0, "R1 reset ser_out", int'(ser_out), 0);
        chk(dut_clk == 1'b0, "R1 reset dut_clk", int'(dut_clk), 0);
        chk(dut_d == 1'b0, "R1 reset dut_d", int'(dut_d), 0);
        rst_n = 1'b1;
        quiet(3, "R1 idle after reset");

        // R8: with clock unqualified a whole packet is ignored
        send_seq(16'b1010_0101, 8);
        quiet(20, "R8 unqualified line ignored");
        @(negedge clk);
        clk_ok = 1'b1;

        // exhaustive sweep over data values and DUT polarity
        for (int inv = 0; inv < 2; inv++) begin
            dut_inv = inv[0];
            for (int v = 0; v < 16; v++) begin
                send_seq({8'h00, 4'b1010, v[3:0]}, 8);
                expect_packet(v[3:0], 1'b0);
            end
        end
        dut_inv = 1'b0;

        // R2: overlapping and shifted pattern alignments
        send_seq(16'b1010_1011, 8);
        expect_packet(4'b1011, 1'b0);
        send_seq(16'b1_1010_0110, 9);
        expect_packet(4'b0110, 1'b0);
        send_seq(16'b101_1010_1001, 11);
        expect_packet(4'b1001, 1'b0);
        send_seq(16'b0_1010_1111, 9);
        expect_packet(4'b1111, 1'b0);
        send_seq(16'b1010_1010, 8);
        expect_packet(4'b1010, 1'b0);

        // R7: line toggling during stimulus and reply is ignored
        dut_inv = 1'b1;
        send_seq(16'b1010_0011, 8);
        expect_packet(4'b0011, 1'b1);
        quiet(12, "R7 no packet from busy-time activity");
        dut_inv = 1'b0;

        // R8: abort during data collection
        send_seq(16'b1010_11, 6);
        @(negedge clk);
        clk_ok = 1'b0;
        @(negedge clk);
        chk(ser_out == 1'b0 && dut_clk == 1'b0, "R8 abort in data",
            int'({ser_out, dut_clk}), 0);
        clk_ok = 1'b1;
        quiet(20, "R8 no stimulus after data abort");

        // R8: abort during stimulus
        send_seq(16'b1010_1100, 8);
        repeat (4) @(negedge clk);
        clk_ok = 1'b0;
        @(negedge clk);
        chk(dut_clk == 1'b0 && ser_out == 1'b0, "R8 abort in stimulus",
            int'({dut_clk, ser_out}), 0);
        clk_ok = 1'b1;
        quiet(24, "R8 no resume after stimulus abort");

        // R8: abort during reply (frame 1010_1111, third bit is 1)
        send_seq(16'b1010_1111, 8);
        repeat (15) @(negedge clk);
        chk(ser_out == 1'b1, "R6 reply bit before abort", int'(ser_out), 1);
        clk_ok = 1'b0;
        @(negedge clk);
        chk(ser_out == 1'b0, "R8 reply aborted", int'(ser_out), 0);
        clk_ok = 1'b1;
        quiet(12, "R8 idle after reply abort");

        // R7: normal packet still works after aborts
        send_seq(16'b1010_0110, 8);
        expect_packet(4'b0110, 1'b0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule